// File: doc/BRIEF.md
# Registered Two-Way Bus Transceiver

This block couples two parallel data buses, called A and B, and moves a word across in either direction. Each direction has its own storage register, its own capture strobe, its own source select and its own output enable. The outgoing word in a direction is either the live value of the opposite bus or the word held in that direction's register. Storage does not depend on the enables, so a bus can be sampled while the block is not driving it.

Each bus appears as an input, output and output-enable triple rather than a tri-state pin. A per-bus drive flag says whether some other agent is driving that bus. A keeper register per bus holds the bus's last known value. The data paths read a bus through its input while another agent drives it, and through its keeper otherwise. When both directions are enabled in live mode and the other agents release the buses, the two buses feed each other through the keepers and keep their last values.

The capture strobes are treated as ordinary synchronous inputs. Each strobe is sampled on the single system clock, and a register loads on the cycle in which its strobe is first seen high.

Top module: `reg_xcvr`

## Requirements
- R1: While `rst_n` is low at a clock edge, both storage registers and both keepers are cleared to zero. In the first cycle after reset, with stored data selected, both outputs read 0.
- R2: The resolved A value is `a_in` when `a_drv` is 1 and `a_hold` otherwise. At a clock edge where `stb_ab` is 1 and was 0 at the previous edge, the A-to-B register loads the resolved A value, whatever the selects and enables are. At every other edge it keeps its value.
- R3: The B-to-A register loads the resolved B value under the same rule, using `stb_ba`. The resolved B value is `b_in` when `b_drv` is 1 and `b_hold` otherwise.
- R4: `b_oe` equals `oe_ab`, which is active high. `a_oe` equals the inverse of `oe_ba_n`, which is active low.
- R5: When `sel_ab` is 0, `b_out` is the resolved A value. When it is 1, `b_out` is the A-to-B register. In the same way, `a_out` follows `sel_ba`, choosing between the resolved B value and the B-to-A register.
- R6: With `oe_ab` = 0 and `oe_ba_n` = 1, neither bus is driven: `a_oe` = `b_oe` = 0.
- R7: At each clock edge a keeper takes its bus input when that bus's drive flag is 1. Otherwise it takes the block's own output for that bus when that output is enabled. Otherwise it keeps its value.
- R8: With both directions enabled, both selects at 0 and both drive flags at 0, both buses keep the last value they held before release, for as long as the condition lasts.
- R9: With both directions enabled and both selects at 1, `b_out` shows the A-to-B register and `a_out` shows the B-to-A register at the same time.
- R10: With both selects at 0, both strobes may rise at the same edge, and each register loads its own bus.
- R11: A strobe held high for several cycles loads its register only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | W | Value seen on bus A |
| a_drv | input | 1 | Another agent is driving bus A |
| b_in | input | W | Value seen on bus B |
| b_drv | input | 1 | Another agent is driving bus B |
| stb_ab | input | 1 | Capture strobe for the A-to-B register |
| stb_ba | input | 1 | Capture strobe for the B-to-A register |
| sel_ab | input | 1 | Source for bus B: 0 live, 1 stored |
| sel_ba | input | 1 | Source for bus A: 0 live, 1 stored |
| oe_ab | input | 1 | Drive bus B, active high |
| oe_ba_n | input | 1 | Drive bus A, active low |
| a_out | output | W | Word offered to bus A |
| a_oe | output | 1 | Block drives bus A |
| b_out | output | W | Word offered to bus B |
| b_oe | output | 1 | Block drives bus B |
| a_hold | output | W | Keeper value of bus A |
| b_hold | output | W | Keeper value of bus B |

## Verification
The bench builds the block at the default width of 8 bits. It uses patterns such as 0xA5, 0x5A, 0x3C and 0xFF, so every bit lane is seen at both levels and a swapped or stuck lane changes a compared word. At this width the keeper loop, stored-versus-live selection and edge-only capture can each be told apart by distinct word values in a handful of cycles.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Which buses the block is driving
  typedef enum logic [1:0] {
    DRV_NONE = 2'b00,
    DRV_B    = 2'b01,
    DRV_A    = 2'b10,
    DRV_BOTH = 2'b11
  } drive_mode_e;

  // Enable decoding: the A-to-B enable is active high, the B-to-A enable active low
  function automatic drive_mode_e decode_drive(input logic en_ab, input logic en_ba_n);
    return drive_mode_e'({~en_ba_n, en_ab});
  endfunction

  // Strobe seen high now and low at the previous sample
  function automatic logic rise_of(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  // Keeper source choice: 2 = external input, 1 = own output, 0 = keep
  function automatic logic [1:0] keep_src(input logic ext_drv, input logic own_oe);
    if (ext_drv)     return 2'd2;
    else if (own_oe) return 2'd1;
    else             return 2'd0;
  endfunction

endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  output logic rise
);
  import xcvr_pkg::*;

  logic stb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb;
  end

  assign rise = rise_of(stb, stb_q);
endmodule

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext_drv,
  input  logic [W-1:0] ext_val,
  input  logic         own_oe,
  input  logic [W-1:0] own_val,
  output logic [W-1:0] hold,
  output logic [W-1:0] bus_view
);
  import xcvr_pkg::*;

  logic [W-1:0] hold_q;
  logic [W-1:0] hold_d;

  always_comb begin
    unique case (keep_src(ext_drv, own_oe))
      2'd2:    hold_d = ext_val;
      2'd1:    hold_d = own_val;
      default: hold_d = hold_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign hold     = hold_q;
  // The data paths see the input while it is driven, else the kept value
  assign bus_view = ext_drv ? ext_val : hold_q;
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic         sel_stored,
  input  logic [W-1:0] src,
  output logic [W-1:0] stored,
  output logic [W-1:0] out
);
  logic [W-1:0] reg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   reg_q <= '0;
    else if (cap) reg_q <= src;
  end

  assign stored = reg_q;
  assign out    = sel_stored ? reg_q : src;
endmodule

// File: rtl/reg_xcvr.sv
module reg_xcvr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic         a_drv,
  input  logic [W-1:0] b_in,
  input  logic         b_drv,
  input  logic         stb_ab,
  input  logic         stb_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         oe_ab,
  input  logic         oe_ba_n,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  output logic [W-1:0] a_hold,
  output logic [W-1:0] b_hold
);
  import xcvr_pkg::*;

  // Named internal events, used by the checker
  logic         ab_cap, ba_cap;
  logic [W-1:0] a_bus, b_bus;
  logic [W-1:0] ab_q, ba_q;
  drive_mode_e  mode;

  assign mode = decode_drive(oe_ab, oe_ba_n);
  assign b_oe = (mode == DRV_B) || (mode == DRV_BOTH);
  assign a_oe = (mode == DRV_A) || (mode == DRV_BOTH);

  xcvr_edge u_edge_ab (.clk(clk), .rst_n(rst_n), .stb(stb_ab), .rise(ab_cap));
  xcvr_edge u_edge_ba (.clk(clk), .rst_n(rst_n), .stb(stb_ba), .rise(ba_cap));

  xcvr_keeper #(.W(W)) u_keep_a (
    .clk(clk), .rst_n(rst_n), .ext_drv(a_drv), .ext_val(a_in),
    .own_oe(a_oe), .own_val(a_out), .hold(a_hold), .bus_view(a_bus)
  );

  xcvr_keeper #(.W(W)) u_keep_b (
    .clk(clk), .rst_n(rst_n), .ext_drv(b_drv), .ext_val(b_in),
    .own_oe(b_oe), .own_val(b_out), .hold(b_hold), .bus_view(b_bus)
  );

  xcvr_path #(.W(W)) u_path_ab (
    .clk(clk), .rst_n(rst_n), .cap(ab_cap), .sel_stored(sel_ab),
    .src(a_bus), .stored(ab_q), .out(b_out)
  );

  xcvr_path #(.W(W)) u_path_ba (
    .clk(clk), .rst_n(rst_n), .cap(ba_cap), .sel_stored(sel_ba),
    .src(b_bus), .stored(ba_q), .out(a_out)
  );
endmodule

// File: rtl/reg_xcvr_chk.sv
module reg_xcvr_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         stb_ab,
  input logic         stb_ba,
  input logic         sel_ab,
  input logic         oe_ab,
  input logic         oe_ba_n,
  input logic         a_drv,
  input logic         b_drv,
  input logic         a_oe,
  input logic         b_oe,
  input logic         ab_cap,
  input logic         ba_cap,
  input logic [W-1:0] a_bus,
  input logic [W-1:0] b_bus,
  input logic [W-1:0] ab_q,
  input logic [W-1:0] ba_q,
  input logic [W-1:0] b_out,
  input logic [W-1:0] a_hold,
  input logic [W-1:0] b_hold
);
  // R2
  ab_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ab_cap |=> ab_q == $past(a_bus));

  // R2
  ab_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ab_cap |=> $stable(ab_q));

  // R3
  ba_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ba_cap |=> ba_q == $past(b_bus));

  // R4
  oe_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_oe == oe_ab) && (a_oe == !oe_ba_n));

  // R6
  isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_ab && oe_ba_n) |-> (!a_oe && !b_oe));

  // R7
  keep_a_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_drv && !a_oe) |=> $stable(a_hold));

  // R7
  keep_b_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_drv && !b_oe) |=> $stable(b_hold));

  // R11
  level_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stb_ab) && stb_ab) |-> !ab_cap);

  // R5
  stored_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ab |-> b_out == ab_q);
endmodule

bind reg_xcvr reg_xcvr_chk #(.W(W)) u_reg_xcvr_chk (
  .clk(clk), .rst_n(rst_n), .stb_ab(stb_ab), .stb_ba(stb_ba),
  .sel_ab(sel_ab), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
  .a_drv(a_drv), .b_drv(b_drv), .a_oe(a_oe), .b_oe(b_oe),
  .ab_cap(ab_cap), .ba_cap(ba_cap), .a_bus(a_bus), .b_bus(b_bus),
  .ab_q(ab_q), .ba_q(ba_q), .b_out(b_out), .a_hold(a_hold), .b_hold(b_hold)
);

// File: tb/tb_reg_xcvr.sv
module tb_reg_xcvr;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a_in, b_in;
  logic         a_drv, b_drv, stb_ab, stb_ba, sel_ab, sel_ba, oe_ab, oe_ba_n;
  logic [W-1:0] a_out, b_out, a_hold, b_hold;
  logic         a_oe, b_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference state, computed from the requirements
  logic [W-1:0] m_ab, m_ba, m_ah, m_bh;
  logic         m_pab, m_pba;

  always #10 clk = ~clk;

  reg_xcvr #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_drv(a_drv), .b_in(b_in), .b_drv(b_drv),
    .stb_ab(stb_ab), .stb_ba(stb_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .oe_ab(oe_ab), .oe_ba_n(oe_ba_n), .a_out(a_out), .a_oe(a_oe),
    .b_out(b_out), .b_oe(b_oe), .a_hold(a_hold), .b_hold(b_hold)
  );

  function automatic logic [W-1:0] ex_abus();
    return a_drv ? a_in : m_ah;
  endfunction
  function automatic logic [W-1:0] ex_bbus();
    return b_drv ? b_in : m_bh;
  endfunction
  function automatic logic [W-1:0] ex_bout();
    return sel_ab ? m_ab : ex_abus();
  endfunction
  function automatic logic [W-1:0] ex_aout();
    return sel_ba ? m_ba : ex_bbus();
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: model updates from inputs held since the last falling edge
  task automatic step();
    logic [W-1:0] nab, nba, nah, nbh;
    @(posedge clk);
    nab = m_ab; nba = m_ba; nah = m_ah; nbh = m_bh;
    if (!rst_n) begin
      nab = '0; nba = '0; nah = '0; nbh = '0;
      m_pab = 1'b0; m_pba = 1'b0;
    end else begin
      if (stb_ab && !m_pab) nab = ex_abus();
      if (stb_ba && !m_pba) nba = ex_bbus();
      if (a_drv) nah = a_in; else if (!oe_ba_n) nah = ex_aout();
      if (b_drv) nbh = b_in; else if (oe_ab)    nbh = ex_bout();
      m_pab = stb_ab; m_pba = stb_ba;
    end
    m_ab = nab; m_ba = nba; m_ah = nah; m_bh = nbh;
    @(negedge clk);
  endtask

  task automatic chk_all(input string req);
    chk({req, " b_oe"}, {7'd0, b_oe}, {7'd0, oe_ab});
    chk({req, " a_oe"}, {7'd0, a_oe}, {7'd0, !oe_ba_n});
    if (b_oe) chk({req, " b_out"}, b_out, ex_bout());
    if (a_oe) chk({req, " a_out"}, a_out, ex_aout());
    chk({req, " a_hold"}, a_hold, m_ah);
    chk({req, " b_hold"}, b_hold, m_bh);
  endtask

  task automatic idle();
    a_drv = 1; b_drv = 1; stb_ab = 0; stb_ba = 0;
    sel_ab = 0; sel_ba = 0; oe_ab = 0; oe_ba_n = 1;
  endtask

  task automatic t_reset();
    rst_n = 0; idle(); a_in = 8'hA5; b_in = 8'h5A;
    step(); step();
    rst_n = 1; a_drv = 0; b_drv = 0; sel_ab = 1; sel_ba = 1; oe_ab = 1; oe_ba_n = 0;
    #1;
    chk("R1 b_out", b_out, 8'h00);
    chk("R1 a_out", a_out, 8'h00);
    chk("R1 a_hold", a_hold, 8'h00);
    chk_all("R1");
  endtask

  // R2 R3: capture with outputs disabled, then show stored words
  task automatic t_capture(input logic [W-1:0] av, input logic [W-1:0] bv);
    idle(); a_in = av; b_in = bv;
    step();
    stb_ab = 1; step();
    stb_ab = 0; stb_ba = 1; a_in = ~av; step();
    stb_ba = 0; b_in = ~bv;
    sel_ab = 1; sel_ba = 1; oe_ab = 1; oe_ba_n = 0; #1;
    chk("R2 stored A", b_out, av);
    chk("R3 stored B", a_out, bv);
    chk_all("R2 R3");
    step();
  endtask

  task automatic t_level();
    idle(); a_in = 8'h3C; step();
    stb_ab = 1; step();
    a_in = 8'hC3; step(); step();
    sel_ab = 1; oe_ab = 1; #1;
    chk("R11 held strobe", b_out, 8'h3C);
    stb_ab = 0; step();
  endtask

  task automatic t_isolate();
    idle(); a_in = 8'h11; b_in = 8'h22; step();
    chk("R6 a_oe", {7'd0, a_oe}, 8'h00);
    chk("R6 b_oe", {7'd0, b_oe}, 8'h00);
    chk_all("R6");
    oe_ab = 1; #1; chk("R4 b_oe high", {7'd0, b_oe}, 8'h01);
    oe_ab = 0; oe_ba_n = 0; #1; chk("R4 a_oe low-active", {7'd0, a_oe}, 8'h01);
    step();
  endtask

  task automatic t_live();
    idle(); oe_ab = 1; oe_ba_n = 0; a_in = 8'h96; b_in = 8'h69; #1;
    chk("R5 live B", b_out, 8'h96);
    chk("R5 live A", a_out, 8'h69);
    a_in = 8'h0F; #1;
    chk("R5 live follows", b_out, 8'h0F);
    sel_ab = 1; #1;
    chk_all("R5 mixed");
    step();
  endtask

  task automatic t_both_stored();
    idle(); a_in = 8'hFF; b_in = 8'h01; stb_ab = 1; step();
    stb_ab = 0; stb_ba = 1; step();
    stb_ba = 0; a_in = 8'h00; b_in = 8'h80;
    sel_ab = 1; sel_ba = 1; oe_ab = 1; oe_ba_n = 0; #1;
    chk("R9 B shows A store", b_out, 8'hFF);
    chk("R9 A shows B store", a_out, 8'h01);
    step();
  endtask

  task automatic t_simul();
    idle(); step();
    a_in = 8'h4D; b_in = 8'hB2; stb_ab = 1; stb_ba = 1; step();
    stb_ab = 0; stb_ba = 0; a_in = 8'h00; b_in = 8'h00;
    sel_ab = 1; sel_ba = 1; oe_ab = 1; oe_ba_n = 0; #1;
    chk("R10 A reg", b_out, 8'h4D);
    chk("R10 B reg", a_out, 8'hB2);
    step();
  endtask

  task automatic t_keeper();
    idle(); a_in = 8'h77; b_in = 8'h88; step();
    chk("R7 take input A", a_hold, 8'h77);
    a_drv = 0; b_drv = 0; a_in = 8'h00; b_in = 8'hFF; step(); step();
    chk("R7 idle keeps A", a_hold, 8'h77);
    chk("R7 idle keeps B", b_hold, 8'h88);
    oe_ab = 1; step();
    chk("R7 own drive B", b_hold, 8'h77);
    chk_all("R7");
    idle(); step();
  endtask

  task automatic t_reinforce();
    idle(); oe_ab = 1; oe_ba_n = 0; a_in = 8'hE1; b_drv = 0; step(); step();
    a_drv = 0; a_in = 8'h00; b_in = 8'h00;
    for (int i = 0; i < 6; i++) begin
      step();
      chk("R8 A kept", a_hold, 8'hE1);
      chk("R8 B kept", b_hold, 8'hE1);
      chk("R8 B driven", b_out, 8'hE1);
    end
    idle(); step();
  endtask

  initial begin
    m_ab = 0; m_ba = 0; m_ah = 0; m_bh = 0; m_pab = 0; m_pba = 0;
    @(negedge clk);
    t_reset();
    t_capture(8'hA5, 8'h5A);
    t_capture(8'h3C, 8'hC3);
    t_level();
    t_isolate();
    t_live();
    t_both_stored();
    t_simul();
    t_keeper();
    t_reinforce();
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule